// File: doc/BRIEF.md
# Left-to-Right Viterbi Recursion Engine

This block scores one word model against a sequence of observation frames. The model has a fixed number of states in a strict left-to-right chain. A state may stay where it is or step forward by exactly one. All scores are natural-log quantities held as signed fixed-point integers, so each product of probabilities becomes a saturating sum. Long sequences therefore never underflow.

A controller pulses `start` with the number of frames. For every frame it then streams one element per state, in ascending state order. Each element carries the state's log output probability, the log self-transition cost of that state, and a difference term. The difference term is the log forward-transition probability into the state minus the log self-transition probability of the state before it. The forward cost into state j is therefore the self cost of state j−1, which arrived with the previous element, plus the difference term that arrives with state j. The engine keeps one partial score per state and updates it in place. Once the last element of the last frame has been accepted, it presents the final state's score together with a one-cycle `done` strobe. Computing the output probabilities and comparing words are handled by other blocks.

Top module: `lr_viterbi_engine`

## Requirements
- R1: After reset, `done` is low and `score` holds the sentinel, the most negative value of the score width (−2^(SCORE_W−1)).
- R2: `start` with a nonzero `frame_count` begins a run of that many frames. `start` with `frame_count` equal to 0 is ignored: no result is ever produced for it, and a later run behaves normally.
- R3: An element is accepted on every clock edge where a run is active and `b_valid` is high. Accepted elements map to state 1..N of frame 1, then state 1..N of frame 2, and so on. Cycles where `b_valid` is low leave the run unchanged.
- R4: In the first frame, state 1 takes its output-probability term unchanged, since the log initial probability of state 1 is 0. Every other state takes the sentinel, and its transition inputs are not used.
- R5: In each later frame, state j becomes max(stay, fwd) + b. Here stay = old(j) + self_j, and fwd = (old(j−1) + self_(j−1)) + diff_j. The value old denotes the previous frame's score. State 1 has no forward candidate. When the two candidates are equal, the stay path is taken.
- R6: Every addition saturates. If either operand is the sentinel, the result is the sentinel. A sum above 2^(SCORE_W−1)−1 clamps to that maximum, and a sum at or below the sentinel clamps to the sentinel.
- R7: `done` is high for exactly one cycle, on the cycle after the edge that accepted the final element. At that cycle `score` carries the final state's score. `score` then stays constant until the next `done`.
- R8: `start` during an active run is ignored, and the run finishes with its original frame count.
- R9: When the frame count is smaller than the number of states, no path reaches the last state, and the result is the sentinel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| frame_count | input | FRAME_W | Number of frames in the run |
| b_valid | input | 1 | Stream element present |
| b_score | input | SCORE_W | Log output probability of the current state (signed) |
| self_cost | input | SCORE_W | Log self-transition of the current state (signed) |
| fwd_diff | input | SCORE_W | Log forward transition into this state minus the previous state's log self-transition (signed) |
| score | output | SCORE_W | Final word score (signed) |
| done | output | 1 | One-cycle strobe marking a valid `score` |

## Verification
The only result is the word score. It appears one edge after the final element is accepted: the engine updates the partial score and registers the output on that same edge, so `done` is visible for the half-cycle that follows. Inputs are driven on falling edges. For each run, a reference model in the bench computes the expected score and queues it before any element is driven. The monitor samples on every falling edge, pops one expected value for each `done`, and checks that `done` never stays high for two cycles and that `score` stays constant between strobes. Any `done` that arrives with nothing queued is reported as a failure, which covers the ignored starts.

// File: rtl/lrv_pkg.sv
package lrv_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/lrv_sat_add.sv
module lrv_sat_add #(
  parameter int W = 20
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);

  localparam logic signed [W-1:0] FLOOR = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] CEIL  = {1'b0, {(W-1){1'b1}}};

  logic signed [W:0] wide;

  always_comb begin
    wide = {a[W-1], a} + {b[W-1], b};
    if ((a == FLOOR) || (b == FLOOR)) begin
      y = FLOOR;
    end else if (wide[W] != wide[W-1]) begin
      y = wide[W] ? FLOOR : CEIL;
    end else begin
      y = wide[W-1:0];
    end
  end

endmodule

// File: rtl/lrv_seq.sv
module lrv_seq
  import lrv_pkg::*;
#(
  parameter int NS  = 5,
  parameter int FW  = 12,
  parameter int SIW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [FW-1:0]  frame_count,
  input  logic           b_valid,
  output logic           accept,
  output logic [SIW-1:0] st_idx,
  output logic           first_frame,
  output logic           first_state,
  output logic           last_elem
);

  localparam logic [SIW-1:0] LAST_ST = SIW'(NS - 1);

  seq_state_e     state_q, state_d;
  logic [SIW-1:0] st_q, st_d;
  logic [FW-1:0]  frm_q, frm_d;
  logic [FW-1:0]  tot_q, tot_d;
  logic           last_state, last_frame;

  always_comb begin
    accept      = (state_q == SEQ_RUN) && b_valid;
    last_state  = (st_q == LAST_ST);
    last_frame  = (frm_q == (tot_q - FW'(1)));
    last_elem   = last_state && last_frame;
    first_frame = (frm_q == '0);
    first_state = (st_q == '0);
    st_idx      = st_q;
  end

  always_comb begin
    state_d = state_q;
    st_d    = st_q;
    frm_d   = frm_q;
    tot_d   = tot_q;
    case (state_q)
      SEQ_IDLE: begin
        if (start && (frame_count != '0)) begin
          state_d = SEQ_RUN;
          st_d    = '0;
          frm_d   = '0;
          tot_d   = frame_count;
        end
      end
      SEQ_RUN: begin
        if (accept) begin
          if (last_state) begin
            st_d  = '0;
            frm_d = frm_q + FW'(1);
            if (last_frame) begin
              state_d = SEQ_IDLE;
            end
          end else begin
            st_d = st_q + SIW'(1);
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      st_q    <= '0;
      frm_q   <= '0;
      tot_q   <= '0;
    end else begin
      state_q <= state_d;
      st_q    <= st_d;
      frm_q   <= frm_d;
      tot_q   <= tot_d;
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    st_q <= LAST_ST); // R3

  AST_ZERO_COUNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE && start && frame_count == '0) |=> (state_q == SEQ_IDLE)); // R2

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RUN && start) |=> $stable(tot_q)); // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RUN && !b_valid) |=> ($stable(st_q) && $stable(frm_q))); // R3

endmodule

// File: rtl/lrv_pe.sv
module lrv_pe #(
  parameter int W = 20
) (
  input  logic               first_frame,
  input  logic               first_state,
  input  logic signed [W-1:0] b_in,
  input  logic signed [W-1:0] self_in,
  input  logic signed [W-1:0] diff_in,
  input  logic signed [W-1:0] cur_score,
  input  logic signed [W-1:0] prev_score,
  input  logic signed [W-1:0] prev_self,
  output logic signed [W-1:0] nxt_score
);

  localparam logic signed [W-1:0] FLOOR = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] stay_c, fwd_a, fwd_b, fwd_c, best_c, sum_c;

  lrv_sat_add #(.W(W)) u_stay (.a(cur_score),  .b(self_in),   .y(stay_c));
  lrv_sat_add #(.W(W)) u_fwd0 (.a(prev_score), .b(prev_self), .y(fwd_a));
  lrv_sat_add #(.W(W)) u_fwd1 (.a(fwd_a),      .b(diff_in),   .y(fwd_b));
  lrv_sat_add #(.W(W)) u_emit (.a(best_c),     .b(b_in),      .y(sum_c));

  always_comb begin
    fwd_c  = first_state ? FLOOR : fwd_b;
    best_c = (stay_c >= fwd_c) ? stay_c : fwd_c;
    if (first_frame) begin
      nxt_score = first_state ? b_in : FLOOR;
    end else begin
      nxt_score = sum_c;
    end
  end

endmodule

// File: rtl/lrv_bank.sv
module lrv_bank #(
  parameter int NS  = 5,
  parameter int W   = 20,
  parameter int SIW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SIW-1:0]     idx,
  input  logic signed [W-1:0] wdata,
  input  logic signed [W-1:0] self_in,
  output logic signed [W-1:0] cur_score,
  output logic signed [W-1:0] hold_score,
  output logic signed [W-1:0] hold_self
);

  localparam logic signed [W-1:0] FLOOR = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] delta_q [NS];
  logic signed [W-1:0] hold_q, pself_q;

  genvar g;
  generate
    for (g = 0; g < NS; g++) begin : g_state
      logic wen;
      always_comb wen = wr_en && (idx == SIW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          delta_q[g] <= FLOOR;
        end else if (wen) begin
          delta_q[g] <= wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= FLOOR;
      pself_q <= '0;
    end else if (wr_en) begin
      hold_q  <= delta_q[idx];
      pself_q <= self_in;
    end
  end

  always_comb begin
    cur_score  = delta_q[idx];
    hold_score = hold_q;
    hold_self  = pself_q;
  end

endmodule

// File: rtl/lr_viterbi_engine.sv
module lr_viterbi_engine #(
  parameter int NUM_STATES = 5,
  parameter int SCORE_W    = 20,
  parameter int FRAME_W    = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [FRAME_W-1:0]        frame_count,
  input  logic                      b_valid,
  input  logic signed [SCORE_W-1:0] b_score,
  input  logic signed [SCORE_W-1:0] self_cost,
  input  logic signed [SCORE_W-1:0] fwd_diff,
  output logic signed [SCORE_W-1:0] score,
  output logic                      done
);

  localparam int SIW = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1;
  localparam logic signed [SCORE_W-1:0] FLOOR = {1'b1, {(SCORE_W-1){1'b0}}};

  logic               accept, first_frame, first_state, last_elem;
  logic [SIW-1:0]     st_idx;
  logic signed [SCORE_W-1:0] cur_s, hold_s, hold_self, nxt_s;
  logic signed [SCORE_W-1:0] score_q, score_d;
  logic               done_q, done_d;

  lrv_seq #(.NS(NUM_STATES), .FW(FRAME_W), .SIW(SIW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_count(frame_count),
    .b_valid(b_valid), .accept(accept), .st_idx(st_idx),
    .first_frame(first_frame), .first_state(first_state), .last_elem(last_elem)
  );

  lrv_bank #(.NS(NUM_STATES), .W(SCORE_W), .SIW(SIW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .idx(st_idx), .wdata(nxt_s),
    .self_in(self_cost), .cur_score(cur_s), .hold_score(hold_s), .hold_self(hold_self)
  );

  lrv_pe #(.W(SCORE_W)) u_pe (
    .first_frame(first_frame), .first_state(first_state), .b_in(b_score),
    .self_in(self_cost), .diff_in(fwd_diff), .cur_score(cur_s),
    .prev_score(hold_s), .prev_self(hold_self), .nxt_score(nxt_s)
  );

  always_comb begin
    done_d  = accept && last_elem;
    score_d = done_d ? nxt_s : score_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      score_q <= FLOOR;
      done_q  <= 1'b0;
    end else begin
      score_q <= score_d;
      done_q  <= done_d;
    end
  end

  assign score = score_q;
  assign done  = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7

  AST_SCORE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && last_elem) |=> $stable(score_q)); // R7

  AST_FIRST_FRAME_SENTINEL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && first_frame && !first_state) |-> (nxt_s == FLOOR)); // R4

  AST_SENTINEL_ABSORB: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !first_frame && b_score == FLOOR) |-> (nxt_s == FLOOR)); // R6

endmodule

// File: tb/lr_viterbi_engine_test.sv
module lr_viterbi_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 5;
  localparam int SW = 20;
  localparam int FW = 12;
  localparam longint FLOOR_V = -(longint'(1) <<< (SW-1));
  localparam longint CEIL_V  = (longint'(1) <<< (SW-1)) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [FW-1:0] frame_count;
  logic b_valid;
  logic signed [SW-1:0] b_score, self_cost, fwd_diff;
  logic signed [SW-1:0] score;
  logic done;

  int checks = 0;
  int failures = 0;
  int done_seen = 0;
  longint exp_q[$];
  string  req_q[$];
  bit     prev_done = 1'b0;
  bit     have_last = 1'b0;
  longint last_score = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lr_viterbi_engine #(.NUM_STATES(NS), .SCORE_W(SW), .FRAME_W(FW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_count(frame_count),
    .b_valid(b_valid), .b_score(b_score), .self_cost(self_cost), .fwd_diff(fwd_diff),
    .score(score), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint sat(input longint x);
    if (x > CEIL_V) return CEIL_V;
    if (x <= FLOOR_V) return FLOOR_V;
    return x;
  endfunction

  function automatic longint sadd(input longint a, input longint b);
    if (a == FLOOR_V || b == FLOOR_V) return FLOOR_V;
    return sat(a + b);
  endfunction

  function automatic longint pick(input int mode, input longint lo, input longint hi);
    return lo + longint'($urandom % (hi - lo + 1));
  endfunction

  // Driver: builds stimulus, computes the expected score, queues it, then streams.
  task automatic run_word(input int frames, input int mode, input bit poke, input string req);
    longint bv[][], sv[][], dv[][];
    longint d[NS], nd[NS];
    bv = new[frames]; sv = new[frames]; dv = new[frames];
    for (int t = 0; t < frames; t++) begin
      bv[t] = new[NS]; sv[t] = new[NS]; dv[t] = new[NS];
      for (int j = 0; j < NS; j++) begin
        case (mode)
          1: begin bv[t][j] = 150000; sv[t][j] = 0; dv[t][j] = 0; end
          2: begin bv[t][j] = -200000; sv[t][j] = -1000; dv[t][j] = 0; end
          3: begin bv[t][j] = -100; sv[t][j] = -10; dv[t][j] = 0; end
          default: begin
            bv[t][j] = pick(mode, -2000, 0);
            sv[t][j] = pick(mode, -500, 0);
            dv[t][j] = pick(mode, -300, 300);
          end
        endcase
      end
    end
    for (int t = 0; t < frames; t++) begin
      for (int j = 0; j < NS; j++) begin
        if (t == 0) begin
          nd[j] = (j == 0) ? bv[t][j] : FLOOR_V;
        end else begin
          longint stay, fwd, best;
          stay = sadd(d[j], sv[t][j]);
          fwd  = (j == 0) ? FLOOR_V : sadd(sadd(d[j-1], sv[t][j-1]), dv[t][j]);
          best = (stay >= fwd) ? stay : fwd;
          nd[j] = sadd(best, bv[t][j]);
        end
      end
      for (int j = 0; j < NS; j++) d[j] = nd[j];
    end
    exp_q.push_back(d[NS-1]);
    req_q.push_back(req);

    @(negedge clk);
    start = 1'b1;
    frame_count = FW'(frames);
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < frames; t++) begin
      for (int j = 0; j < NS; j++) begin
        if (($urandom % 4) == 0) begin
          b_valid = 1'b0;
          @(negedge clk);
        end
        b_valid   = 1'b1;
        b_score   = bv[t][j][SW-1:0];
        self_cost = sv[t][j][SW-1:0];
        fwd_diff  = dv[t][j][SW-1:0];
        if (poke && t == 1 && j == 2) begin
          start = 1'b1;
          frame_count = FW'(2);
        end
        @(negedge clk);
        start = 1'b0;
      end
    end
    b_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Monitor: pops one expected value per done strobe.
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        done_seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected result", longint'(score), 0);
        end else begin
          longint e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          chk(longint'(score) == e, r, longint'(score), e);
        end
        chk(!prev_done, "R7 done width", 2, 1);
        last_score = longint'(score);
        have_last = 1'b1;
      end else if (have_last && longint'(score) != last_score) begin
        chk(1'b0, "R7 score held", longint'(score), last_score);
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seen0;
    rst_n = 1'b0;
    start = 1'b0;
    frame_count = '0;
    b_valid = 1'b0;
    b_score = '0;
    self_cost = '0;
    fwd_diff = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", longint'(done), 0);
    chk(longint'(score) == FLOOR_V, "R1 score after reset", longint'(score), FLOOR_V);
    rst_n = 1'b1;
    @(negedge clk);

    run_word(1, 0, 1'b0, "R4 R9 single frame");
    run_word(4, 0, 1'b0, "R9 too few frames");
    run_word(5, 0, 1'b0, "R5 exact path");
    run_word(5, 3, 1'b0, "R5 tie stay path");
    run_word(12, 0, 1'b0, "R3 R5 random A");
    run_word(9, 0, 1'b0, "R3 R5 random B");
    run_word(12, 1, 1'b0, "R6 clamp to max");
    run_word(12, 2, 1'b0, "R6 clamp to sentinel");

    seen0 = done_seen;
    @(negedge clk);
    start = 1'b1;
    frame_count = '0;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(done_seen == seen0, "R2 zero count ignored", done_seen - seen0, 0);

    run_word(7, 0, 1'b0, "R2 run after zero start");
    run_word(8, 0, 1'b1, "R8 start while busy");
    run_word(6, 0, 1'b0, "R8 next run");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all results produced", exp_q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule